// File: doc/BRIEF.md
# Out-of-Order Pixel Coalescing Writer

This block sits between a group of ray-processing cores and a frame buffer. Each core hands over finished pixels one at a time, each tagged with its linear pixel index and a 12-bit colour. Pixels that need secondary rays finish late, so results reach the block in no useful order. The block sorts them into a pool of eight line caches. Each cache covers sixteen horizontally adjacent pixels that share an aligned base index. A cache goes to the frame buffer as one sixteen-beat burst, and only once every one of its pixels is present.

Each cycle a fixed-priority arbiter picks one presenting core. The pixel goes to the open cache whose base matches. If no cache matches, the lowest-numbered free cache is claimed. When no cache matches and none is free, the granted core sees ready held low until a burst completes and frees a cache. Full caches are drained one at a time, lowest-numbered first. A beat advances only in a cycle where the frame buffer acknowledges it.

Top module: `pixel_coalescer`

## Requirements
- R1: Out of reset no burst is requested, no core sees ready, and all eight caches are free, so eight pixels with distinct bases are each accepted in their first presented cycle.
- R2: A pixel with index p is held in the cache whose base is p with its low four bits cleared, at slot p[3:0]. The colour written for address p equals the 12-bit colour given with it, unchanged (bits 11:8 red, 7:4 green, 3:0 blue).
- R3: A burst for a base starts only after all sixteen pixels of that base have been accepted. A partly filled cache is never written.
- R4: A burst is sixteen beats at addresses base to base+15 in ascending order, with base a multiple of 16. A beat completes in a cycle where the write request and the acknowledge are both high. The last-beat flag is high on the sixteenth beat only. While the acknowledge is low, request, address and data hold.
- R5: Pixels of one cache may arrive in any order and from any core, and the burst content is the same.
- R6: When the granted pixel matches no open cache and no cache is free, ready stays low for that core until a burst has completed.
- R7: A cache is released in the cycle its last beat is acknowledged, and it can be claimed again afterwards. The request drops for at least one cycle between bursts.
- R8: When several caches are full, the lowest-numbered one is drained first, and only one burst is in progress at a time.
- R9: At most one core sees ready in a cycle. A core sees ready only if it presents a pixel and no lower-numbered core presents one.
- R10: A new base claims the lowest-numbered free cache.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resValid | input | NUM_CORES | Per-core pixel present |
| resIdx | input | NUM_CORES*IDX_W | Per-core pixel index, core c at bits c*IDX_W upward |
| resColor | input | NUM_CORES*COLOR_W | Per-core 12-bit colour, core c at bits c*COLOR_W upward |
| resReady | output | NUM_CORES | Per-core acceptance, a transfer happens when valid and ready are both high |
| fbValid | output | 1 | Burst beat request |
| fbAddr | output | IDX_W | Pixel address of the current beat |
| fbData | output | COLOR_W | Colour of the current beat |
| fbLast | output | 1 | High on the sixteenth beat of a burst |
| fbAck | input | 1 | Frame buffer accepts the current beat |

## Verification
The hardest state to reach is a pool with all eight caches claimed, a ninth base waiting on a lower-priority core, and several caches full at once while a burst is stalled. The bench holds the acknowledge low. It opens eight caches with one pixel each and parks core 1 on a new base. It then fills caches 5, 3 and 1 from core 0 in that order before it releases the acknowledge. This shows the stall, the held beat, the lowest-numbered draining order (5, then 1, then 3), and the admission of the parked pixel only after the first burst ends.

// File: rtl/pixcoal_pkg.sv
package pixcoal_pkg;
  parameter int NUM_CORES  = 2;
  parameter int NUM_SETS   = 8;
  parameter int SET_PIXELS = 16;

  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int SET_W  = $clog2(NUM_SETS);
  localparam int OFF_W  = $clog2(SET_PIXELS);

  // strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic              alloc;
    logic [SET_W-1:0]  wrSet;
    logic [CORE_W-1:0] grantCore;
    logic [SET_W-1:0]  flushSet;
    logic [OFF_W-1:0]  beat;
    logic              relSet;
  } ctrl_t;
endpackage

// File: rtl/pixcoal_datapath.sv
module pixcoal_datapath
  import pixcoal_pkg::*;
#(
  parameter int IDX_W   = 16,
  parameter int COLOR_W = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrl_t                          ctl,
  input  logic [NUM_CORES*IDX_W-1:0]     resIdx,
  input  logic [NUM_CORES*COLOR_W-1:0]   resColor,
  output logic [NUM_SETS-1:0]            setBusy,
  output logic [NUM_SETS-1:0]            setFull,
  output logic [NUM_SETS-1:0]            setHit,
  output logic [IDX_W-1:0]               fbAddr,
  output logic [COLOR_W-1:0]             fbData
);
  logic [IDX_W-1:0]      tagQ  [NUM_SETS];
  logic [SET_PIXELS-1:0] maskQ [NUM_SETS];
  logic [NUM_SETS-1:0]   busyQ;
  logic [COLOR_W-1:0]    pixQ  [NUM_SETS][SET_PIXELS];

  logic [IDX_W-1:0]   inIdx;
  logic [IDX_W-1:0]   inBase;
  logic [OFF_W-1:0]   inOff;
  logic [COLOR_W-1:0] inColor;

  assign inIdx   = resIdx[ctl.grantCore*IDX_W +: IDX_W];
  assign inColor = resColor[ctl.grantCore*COLOR_W +: COLOR_W];
  assign inBase  = {inIdx[IDX_W-1:OFF_W], {OFF_W{1'b0}}};
  assign inOff   = inIdx[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= '0;
      for (int s = 0; s < NUM_SETS; s++) begin
        tagQ[s]  <= '0;
        maskQ[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NUM_SETS; s++) begin
        if (ctl.relSet && ctl.flushSet == SET_W'(s)) begin
          busyQ[s] <= 1'b0;
          maskQ[s] <= '0;
        end
        if (ctl.alloc && ctl.wrSet == SET_W'(s)) begin
          busyQ[s] <= 1'b1;
          tagQ[s]  <= inBase;
        end
        if (ctl.wrEn && ctl.wrSet == SET_W'(s))
          maskQ[s][inOff] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.wrEn)
      pixQ[ctl.wrSet][inOff] <= inColor;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SETS; g++) begin : g_flags
      assign setFull[g] = &maskQ[g];
      assign setHit[g]  = busyQ[g] && !setFull[g] && (tagQ[g] == inBase);
    end
  endgenerate

  assign setBusy = busyQ;
  assign fbAddr  = {tagQ[ctl.flushSet][IDX_W-1:OFF_W], ctl.beat};
  assign fbData  = pixQ[ctl.flushSet][ctl.beat];

  // R3
  release_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.relSet |-> setFull[ctl.flushSet]);

  // R6
  write_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |-> (ctl.alloc ? !busyQ[ctl.wrSet] : setHit[ctl.wrSet]));

  // R2
  tag_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrEn |=> tagQ[$past(ctl.wrSet)] == $past(inBase));
endmodule

// File: rtl/pixcoal_ctrl.sv
module pixcoal_ctrl
  import pixcoal_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CORES-1:0] resValid,
  input  logic [NUM_SETS-1:0]  setBusy,
  input  logic [NUM_SETS-1:0]  setFull,
  input  logic [NUM_SETS-1:0]  setHit,
  input  logic                 fbAck,
  output ctrl_t                ctl,
  output logic [NUM_CORES-1:0] resReady,
  output logic                 fbValid,
  output logic                 fbLast
);
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(SET_PIXELS - 1);

  logic [CORE_W-1:0] grantIdx;
  logic              anyValid;
  logic [SET_W-1:0]  hitIdx, freeIdx, fullIdx;
  logic              anyHit, anyFree, anyFull, canTake;

  logic              flushingQ;
  logic [SET_W-1:0]  flushSetQ;
  logic [OFF_W-1:0]  beatQ;

  always_comb begin
    grantIdx = '0;
    anyValid = 1'b0;
    for (int i = NUM_CORES - 1; i >= 0; i--)
      if (resValid[i]) begin
        grantIdx = CORE_W'(i);
        anyValid = 1'b1;
      end
    hitIdx = '0; anyHit = 1'b0;
    freeIdx = '0; anyFree = 1'b0;
    fullIdx = '0; anyFull = 1'b0;
    for (int s = NUM_SETS - 1; s >= 0; s--) begin
      if (setHit[s])   begin hitIdx  = SET_W'(s); anyHit  = 1'b1; end
      if (!setBusy[s]) begin freeIdx = SET_W'(s); anyFree = 1'b1; end
      if (setFull[s])  begin fullIdx = SET_W'(s); anyFull = 1'b1; end
    end
  end

  assign canTake = anyValid && (anyHit || anyFree);

  always_comb begin
    resReady = '0;
    if (canTake) resReady[grantIdx] = 1'b1;
    ctl           = '0;
    ctl.wrEn      = canTake;
    ctl.alloc     = canTake && !anyHit;
    ctl.wrSet     = anyHit ? hitIdx : freeIdx;
    ctl.grantCore = grantIdx;
    ctl.flushSet  = flushSetQ;
    ctl.beat      = beatQ;
    ctl.relSet    = flushingQ && fbAck && (beatQ == LAST_BEAT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushingQ <= 1'b0;
      flushSetQ <= '0;
      beatQ     <= '0;
    end else if (!flushingQ) begin
      if (anyFull) begin
        flushingQ <= 1'b1;
        flushSetQ <= fullIdx;
        beatQ     <= '0;
      end
    end else if (fbAck) begin
      if (beatQ == LAST_BEAT) flushingQ <= 1'b0;
      else                    beatQ <= beatQ + 1'b1;
    end
  end

  assign fbValid = flushingQ;
  assign fbLast  = flushingQ && (beatQ == LAST_BEAT);

  logic [NUM_SETS-1:0] belowFlush;
  assign belowFlush = (NUM_SETS'(1) << flushSetQ) - NUM_SETS'(1);

  // R9
  ready_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(resReady) && ((resReady & ~resValid) == '0));

  genvar c;
  generate
    for (c = 1; c < NUM_CORES; c++) begin : g_prio
      // R9
      ready_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
        resReady[c] |-> !(|resValid[c-1:0]));
    end
  endgenerate

  // R4
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fbValid && !fbAck) |=> (fbValid && $stable(ctl.beat) && $stable(ctl.flushSet)));

  // R7
  release_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.relSet |=> (!fbValid && !setBusy[$past(ctl.flushSet)]));

  // R8
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fbValid) |-> (($past(setFull) & belowFlush) == '0));
endmodule

// File: rtl/pixel_coalescer.sv
module pixel_coalescer
  import pixcoal_pkg::*;
#(
  parameter int IDX_W   = 16,
  parameter int COLOR_W = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CORES-1:0]         resValid,
  input  logic [NUM_CORES*IDX_W-1:0]   resIdx,
  input  logic [NUM_CORES*COLOR_W-1:0] resColor,
  output logic [NUM_CORES-1:0]         resReady,
  output logic                         fbValid,
  output logic [IDX_W-1:0]             fbAddr,
  output logic [COLOR_W-1:0]           fbData,
  output logic                         fbLast,
  input  logic                         fbAck
);
  ctrl_t               ctl;
  logic [NUM_SETS-1:0] setBusy, setFull, setHit;

  pixcoal_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .resValid (resValid),
    .setBusy  (setBusy),
    .setFull  (setFull),
    .setHit   (setHit),
    .fbAck    (fbAck),
    .ctl      (ctl),
    .resReady (resReady),
    .fbValid  (fbValid),
    .fbLast   (fbLast)
  );

  pixcoal_datapath #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .resIdx   (resIdx),
    .resColor (resColor),
    .setBusy  (setBusy),
    .setFull  (setFull),
    .setHit   (setHit),
    .fbAddr   (fbAddr),
    .fbData   (fbData)
  );
endmodule

// File: tb/sim_pixel_coalescer.sv
`timescale 1ns/1ps
module sim_pixel_coalescer;
  localparam int NC = 2;
  localparam int IW = 16;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC-1:0]    resValid = '0;
  logic [NC*IW-1:0] resIdx = '0;
  logic [NC*CW-1:0] resColor = '0;
  logic [NC-1:0]    resReady;
  logic fbValid, fbLast;
  logic fbAck = 1'b0;
  logic [IW-1:0] fbAddr;
  logic [CW-1:0] fbData;

  always #2 clk = ~clk;

  pixel_coalescer u0 (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resIdx(resIdx),
    .resColor(resColor), .resReady(resReady), .fbValid(fbValid),
    .fbAddr(fbAddr), .fbData(fbData), .fbLast(fbLast), .fbAck(fbAck)
  );

  int vectors = 0;
  int miscompares = 0;
  int burstsDone = 0;
  bit finished = 0;
  int pending[$];
  int burstOrder[$];
  int sentCnt[int];

  function automatic logic [CW-1:0] colorOf(int idx);
    return CW'(idx * 37 + 5) ^ 12'hA5A;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: presents one pixel, returns the number of stalled cycles
  task automatic send(int c, int idx, output int waits);
    int base;
    waits = 0;
    @(negedge clk);
    resValid[c] = 1'b1;
    resIdx[c*IW +: IW] = IW'(idx);
    resColor[c*CW +: CW] = colorOf(idx);
    #1;
    while (!resReady[c]) begin
      @(negedge clk); #1;
      waits++;
    end
    @(posedge clk);
    #1 resValid[c] = 1'b0;
    base = idx & ~15;
    if (!sentCnt.exists(base)) sentCnt[base] = 0;
    sentCnt[base] = sentCnt[base] + 1;
    if (sentCnt[base] == 16) begin
      pending.push_back(base);
      sentCnt[base] = 0;
    end
  endtask

  task automatic sendRange(int c, int base, int first);
    int w;
    for (int i = first; i < 16; i++) send(c, base + i, w);
  endtask

  task automatic setAck(bit v);
    @(posedge clk); #1 fbAck = v;
  endtask

  // monitor
  int beatCnt = 0;
  int curBase = 0;
  bit holdPrev = 0;
  int prevAddr = 0;
  always @(negedge clk) begin
    #1;
    if (rstN) begin
      if (&resValid)
        check(!resReady[1], "R9 lower core granted", resReady, 1);
      if (holdPrev)
        check(fbValid && int'(fbAddr) == prevAddr, "R4 beat held", fbAddr, prevAddr);
      if (fbValid && fbAck) begin
        if (beatCnt == 0) begin
          int pos;
          curBase = fbAddr;
          check(curBase % 16 == 0, "R4 base aligned", curBase, curBase & ~15);
          pos = -1;
          foreach (pending[k]) if (pending[k] == curBase) pos = k;
          check(pos >= 0, "R3 burst of incomplete set", curBase, -1);
          if (pos >= 0) pending.delete(pos);
          burstOrder.push_back(curBase);
        end
        check(int'(fbAddr) == curBase + beatCnt, "R4 beat address", fbAddr, curBase + beatCnt);
        check(fbData == colorOf(fbAddr), "R2 colour", fbData, colorOf(fbAddr));
        check(fbLast == (beatCnt == 15), "R4 last flag", fbLast, beatCnt == 15);
        beatCnt = (beatCnt + 1) % 16;
        if (beatCnt == 0) burstsDone++;
      end
      holdPrev = fbValid && !fbAck;
      prevAddr = fbAddr;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int w;
    int b0;
    int waitsNinth;
    int doneAtAccept;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(!fbValid && resReady == '0, "R1 reset outputs", {fbValid, resReady}, 0);
    #1 rstN = 1'b1;
    @(negedge clk); #1;
    check(!fbValid, "R1 idle after reset", fbValid, 0);
    setAck(1);

    // in-order single set
    sendRange(0, 'h000, 0);
    wait (burstsDone == 1);
    check(burstOrder[0] == 'h000, "R4 first burst base", burstOrder[0], 'h000);

    // shuffled arrival, R5
    for (int i = 0; i < 16; i++) send(0, 'h40 + ((i * 7 + 3) & 15), w);
    wait (burstsDone == 2);
    check(burstOrder[1] == 'h40, "R5 shuffled set", burstOrder[1], 'h40);

    // two cores interleaved, R5 R9
    fork
      for (int i = 0; i < 16; i++) send(0, 'h100 + ((i * 5 + 1) & 15), w);
      for (int i = 0; i < 16; i++) send(1, 'h110 + (15 - i), w);
    join
    wait (burstsDone == 4);
    check(pending.size() == 0, "R5 both sets drained", pending.size(), 0);

    // full pool, stalled burst, priority
    setAck(0);
    for (int k = 0; k < 8; k++) begin
      send(0, 'h200 + 16 * k, w);
      check(w == 0, "R1 R7 free set accepted at once", w, 0);
    end
    b0 = burstsDone;
    fork
      begin
        send(1, 'h300, waitsNinth);
        doneAtAccept = burstsDone;
        check(doneAtAccept > b0, "R6 ninth base waits for a burst", doneAtAccept, b0 + 1);
      end
      begin
        repeat (5) begin
          @(negedge clk); #1;
          check(!resReady[1], "R6 no room", resReady[1], 0);
        end
        sendRange(0, 'h250, 1);
        sendRange(0, 'h230, 1);
        sendRange(0, 'h210, 1);
        repeat (4) begin
          @(negedge clk); #1;
          check(fbValid && fbAddr == 'h250, "R4 stalled beat", fbAddr, 'h250);
        end
        setAck(1);
      end
    join
    wait (burstsDone == b0 + 3);
    check(burstOrder[b0] == 'h250, "R8 first full", burstOrder[b0], 'h250);
    check(burstOrder[b0 + 1] == 'h210, "R8 R10 lowest set next", burstOrder[b0 + 1], 'h210);
    check(burstOrder[b0 + 2] == 'h230, "R8 R10 then set 3", burstOrder[b0 + 2], 'h230);

    // drain everything left
    sendRange(0, 'h200, 1);
    sendRange(0, 'h220, 1);
    sendRange(0, 'h240, 1);
    sendRange(0, 'h260, 1);
    sendRange(0, 'h270, 1);
    sendRange(0, 'h300, 1);
    wait (burstsDone == b0 + 9);
    repeat (3) @(negedge clk);
    #1;
    check(pending.size() == 0, "R3 all complete sets written", pending.size(), 0);
    check(!fbValid, "R7 idle after drain", fbValid, 0);

    // all sets reusable again
    for (int k = 0; k < 8; k++) begin
      send(k % 2, 'h400 + 16 * k, w);
      check(w == 0, "R7 released sets reusable", w, 0);
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule